// File: doc/BRIEF.md
# Error-Correcting Set-Associative Cache with Line Retirement

This block holds the data array of a small set-associative cache. Each line holds one 64-bit word stored as a 72-bit extended Hamming codeword. Every lookup decodes the stored word. When a single bit has flipped, the requester receives the corrected word. One cycle later the repaired codeword is written back into the array. When two bits have flipped, the response is marked uncorrectable and the data is not repaired.

Each line keeps a count of the correctable errors it has produced. When that count reaches a threshold, the line is retired. A retired line is recorded in a small table. From then on, lookups treat it as empty and allocation never picks it. The table holds six entries. When the sixth line is retired, the block raises a flag that asks the rest of the system to deconfigure the cache. No further lines are retired after that.

Requests use a valid/ready handshake and get a one-cycle response pulse. Line fills arrive on a second valid/ready port. That port carries a mask that is XORed into the stored codeword, so array faults can be modelled.

Top module: `secded_line_cache`

## Requirements
- R1: A lookup that hits a line with exactly one flipped codeword bit (any of bits 0..71) returns the original data with `rsp_ce`=1 and `rsp_ue`=0.
- R2: After a correctable hit, the repaired codeword is written back, so the next lookup of that line returns `rsp_ce`=0 with the same data.
- R3: A lookup that hits a line with exactly two flipped bits returns `rsp_ue`=1 and `rsp_ce`=0. The line is not repaired, so a repeat lookup is also uncorrectable.
- R4: The write-back takes one cycle. `req_ready` is 0 in the cycle that follows the acceptance of a correctable hit, and it is 1 again in the cycle after that.
- R5: Each line counts its correctable errors. The lookup that brings the count to `THRESH` (default 2) still returns corrected data, and the line is then retired, so later lookups of it miss.
- R6: The count restarts at zero when a fill places a new tag into the way. A fill that updates the tag already resident in the way keeps the count.
- R7: A retired way is never chosen by a fill. When every way of a set is retired, a fill to that set is accepted and leaves the set unchanged.
- R8: At most `MAX_DEL` (6) lines are retired. `deconf` rises when the sixth line is retired and stays high until reset. Once the table is full, a line that reaches the threshold keeps serving hits.
- R9: Every accepted request produces `rsp_valid` for exactly one cycle, in the cycle after acceptance. A miss, either an invalid line or a tag mismatch, returns `rsp_hit`=0, `rsp_ce`=0 and `rsp_ue`=0.
- R10: After reset, all lines are empty, `req_ready` is 1, `rsp_valid` is 0 and `deconf` is 0.
- R11: A fill goes to the way that already holds its tag if there is one. Otherwise it goes to the lowest-numbered usable empty way. Otherwise it goes to the first usable way at or after the set's round-robin pointer, and the pointer then moves one past that way.
- R12: Requests have priority over fills. `fill_ready` is 0 while `req_valid` is 1 and during a write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup can be accepted |
| req_addr | input | TAG_W+IDX_W | Lookup address: tag above, set index in the low bits |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ce | output | 1 | Single-bit error corrected |
| rsp_ue | output | 1 | Uncorrectable error |
| rsp_data | output | 64 | Returned data word |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill can be accepted |
| fill_addr | input | TAG_W+IDX_W | Fill address, same split as the lookup address |
| fill_data | input | 64 | Fill data word |
| fill_flip | input | 72 | Mask XORed into the stored codeword (fault model) |
| deconf | output | 1 | Retirement table full; cache should be deconfigured |

## Verification
The assertions take for granted that the requester holds `req_valid` until it is accepted. They also take for granted that no fill is offered in a way that would collide with a lookup. The handshake rule of R12 guarantees the second point at the ports. The assertions further assume that flip masks never carry more than two set bits, because a code of this kind gives no guarantee beyond two errors. The bench respects all of this. It drives each request or fill only while the matching ready is high, drops it after one accepted edge, and builds every flip mask from at most two distinct bit positions.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DW = 64;
    localparam int CW = 72;
    localparam int SW = 7;

    function automatic logic [SW-1:0] ecc_syndrome(input logic [CW-1:0] c);
        logic [SW-1:0] s;
        s = '0;
        for (int p = 1; p < CW; p++) begin
            if (c[p]) s = s ^ SW'(p);
        end
        return s;
    endfunction

    function automatic logic [CW-1:0] ecc_encode(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        logic [SW-1:0] s;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        s = ecc_syndrome(c);
        for (int i = 0; i < SW; i++) c[1 << i] = s[i];
        c[0] = ^c;
        return c;
    endfunction

    function automatic logic [DW-1:0] ecc_extract(input logic [CW-1:0] c);
        logic [DW-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] code_o
);
    always_comb code_o = ecc_encode(data_i);
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [CW-1:0] code_i,
    output logic [DW-1:0] data_o,
    output logic          ce_o,
    output logic          ue_o,
    output logic [CW-1:0] fixed_o
);
    logic [SW-1:0] syn;
    logic          par;
    logic          in_range;

    always_comb begin
        syn      = ecc_syndrome(code_i);
        par      = ^code_i;
        in_range = (syn <= SW'(CW - 1));
        ce_o     = par && in_range;
        ue_o     = (!par && (syn != '0)) || (par && !in_range);
        fixed_o  = code_i;
        if (ce_o) begin
            for (int i = 0; i < CW; i++) begin
                if (syn == SW'(i)) fixed_o[i] = ~code_i[i];
            end
        end
        data_o = ecc_extract(fixed_o);
    end
endmodule

// File: rtl/secded_way_pick.sv
module secded_way_pick #(
    parameter int WAYS  = 2,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  hit_i,
    input  logic [WAYS-1:0]  usable_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             ok_o,
    output logic             evict_o
);
    int t;

    always_comb begin
        way_o   = '0;
        ok_o    = 1'b0;
        evict_o = 1'b0;
        t       = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_i[w] && usable_i[w]) begin
                way_o = WAY_W'(w);
                ok_o  = 1'b1;
            end
        end
        if (!ok_o) begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (usable_i[w] && !valid_i[w]) begin
                    way_o = WAY_W'(w);
                    ok_o  = 1'b1;
                end
            end
        end
        if (!ok_o) begin
            for (int k = WAYS - 1; k >= 0; k--) begin
                t = (int'(rr_i) + k) % WAYS;
                if (usable_i[t]) begin
                    way_o   = WAY_W'(t);
                    ok_o    = 1'b1;
                    evict_o = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/secded_line_cache.sv
module secded_line_cache
    import secded_pkg::*;
#(
    parameter int SETS    = 4,
    parameter int WAYS    = 2,
    parameter int TAG_W   = 8,
    parameter int THRESH  = 2,
    parameter int MAX_DEL = 6,
    localparam int IDX_W  = $clog2(SETS),
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_ce,
    output logic              rsp_ue,
    output logic [DW-1:0]     rsp_data,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DW-1:0]     fill_data,
    input  logic [CW-1:0]     fill_flip,
    output logic              deconf
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int CNT_W  = $clog2(THRESH + 1);
    localparam int DCNT_W = $clog2(MAX_DEL + 1);
    localparam int KEY_W  = IDX_W + WAY_W;

    typedef struct packed {
        logic                                     wb;
        logic [SETS-1:0][WAYS-1:0]                vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tag;
        logic [SETS-1:0][WAYS-1:0][CW-1:0]        code;
        logic [SETS-1:0][WAYS-1:0][CNT_W-1:0]     cnt;
        logic [SETS-1:0][WAY_W-1:0]               rr;
        logic [MAX_DEL-1:0][KEY_W-1:0]            dtab;
        logic [DCNT_W-1:0]                        dcnt;
        logic                                     deconf;
        logic [IDX_W-1:0]                         wb_set;
        logic [WAY_W-1:0]                         wb_way;
        logic [CW-1:0]                            wb_code;
        logic                                     rsp_valid;
        logic                                     rsp_hit;
        logic                                     rsp_ce;
        logic                                     rsp_ue;
        logic [DW-1:0]                            rsp_data;
    } state_t;

    state_t q, d;

    // retired-way mask derived from the table
    logic [SETS-1:0][WAYS-1:0] del_m;

    always_comb begin
        del_m = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int e = 0; e < MAX_DEL; e++) begin
                    if ((DCNT_W'(e) < q.dcnt) && (q.dtab[e] == {IDX_W'(s), WAY_W'(w)}))
                        del_m[s][w] = 1'b1;
                end
            end
        end
    end

    // lookup path
    logic [IDX_W-1:0] r_idx;
    logic [TAG_W-1:0] r_tag;
    logic [WAYS-1:0]  r_hitv;
    logic [WAY_W-1:0] r_way;
    logic             r_hit;
    logic [CW-1:0]    r_code;
    logic [DW-1:0]    dec_data;
    logic             dec_ce;
    logic             dec_ue;
    logic [CW-1:0]    dec_fixed;

    always_comb begin
        r_idx = req_addr[IDX_W-1:0];
        r_tag = req_addr[ADDR_W-1:IDX_W];
        r_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            r_hitv[w] = q.vld[r_idx][w] && !del_m[r_idx][w] && (q.tag[r_idx][w] == r_tag);
            if (r_hitv[w]) r_way = WAY_W'(w);
        end
        r_hit  = |r_hitv;
        r_code = q.code[r_idx][r_way];
    end

    secded_dec u_dec (
        .code_i  (r_code),
        .data_o  (dec_data),
        .ce_o    (dec_ce),
        .ue_o    (dec_ue),
        .fixed_o (dec_fixed)
    );

    // fill path
    logic [IDX_W-1:0] f_idx;
    logic [TAG_W-1:0] f_tag;
    logic [WAYS-1:0]  f_hitv;
    logic [WAY_W-1:0] f_way;
    logic             f_ok;
    logic             f_evict;
    logic [CW-1:0]    f_code;

    always_comb begin
        f_idx = fill_addr[IDX_W-1:0];
        f_tag = fill_addr[ADDR_W-1:IDX_W];
        for (int w = 0; w < WAYS; w++)
            f_hitv[w] = q.vld[f_idx][w] && (q.tag[f_idx][w] == f_tag);
    end

    secded_enc u_enc (
        .data_i (fill_data),
        .code_o (f_code)
    );

    secded_way_pick #(.WAYS(WAYS)) u_pick (
        .hit_i    (f_hitv),
        .usable_i (~del_m[f_idx]),
        .valid_i  (q.vld[f_idx]),
        .rr_i     (q.rr[f_idx]),
        .way_o    (f_way),
        .ok_o     (f_ok),
        .evict_o  (f_evict)
    );

    // next-state logic
    logic [CNT_W-1:0] cnt_cur;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        d.rsp_hit   = 1'b0;
        d.rsp_ce    = 1'b0;
        d.rsp_ue    = 1'b0;
        d.rsp_data  = '0;
        req_ready   = !q.wb;
        fill_ready  = !q.wb && !req_valid;
        cnt_cur     = q.cnt[q.wb_set][q.wb_way];
        cnt_nx      = (cnt_cur >= CNT_W'(THRESH)) ? cnt_cur : cnt_cur + CNT_W'(1);

        if (q.wb) begin
            d.wb                       = 1'b0;
            d.code[q.wb_set][q.wb_way] = q.wb_code;
            d.cnt[q.wb_set][q.wb_way]  = cnt_nx;
            if ((cnt_nx == CNT_W'(THRESH)) && (q.dcnt < DCNT_W'(MAX_DEL))) begin
                d.vld[q.wb_set][q.wb_way] = 1'b0;
                for (int e = 0; e < MAX_DEL; e++) begin
                    if (q.dcnt == DCNT_W'(e)) d.dtab[e] = {q.wb_set, q.wb_way};
                end
                d.dcnt = q.dcnt + DCNT_W'(1);
                if (q.dcnt + DCNT_W'(1) == DCNT_W'(MAX_DEL)) d.deconf = 1'b1;
            end
        end else if (req_valid) begin
            d.rsp_valid = 1'b1;
            d.rsp_hit   = r_hit;
            if (r_hit) begin
                d.rsp_data = dec_data;
                d.rsp_ce   = dec_ce;
                d.rsp_ue   = dec_ue;
                if (dec_ce) begin
                    d.wb      = 1'b1;
                    d.wb_set  = r_idx;
                    d.wb_way  = r_way;
                    d.wb_code = dec_fixed;
                end
            end
        end else if (fill_valid && f_ok) begin
            d.vld[f_idx][f_way]  = 1'b1;
            d.tag[f_idx][f_way]  = f_tag;
            d.code[f_idx][f_way] = f_code ^ fill_flip;
            if (!f_hitv[f_way]) d.cnt[f_idx][f_way] = '0;
            if (f_evict) d.rr[f_idx] = WAY_W'((int'(f_way) + 1) % WAYS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_hit   = q.rsp_hit;
    assign rsp_ce    = q.rsp_ce;
    assign rsp_ue    = q.rsp_ue;
    assign rsp_data  = q.rsp_data;
    assign deconf    = q.deconf;
endmodule

// File: rtl/secded_cache_chk.sv
module secded_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic fill_ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic rsp_ce,
    input logic rsp_ue,
    input logic deconf
);
    AST_CE_UE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_ce && rsp_ue)); // R3
    AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ce) |-> (!req_ready && !fill_ready)); // R4
    AST_WB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ce) |=> req_ready); // R4
    AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R9
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid); // R9
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (!rsp_ce && !rsp_ue)); // R9
    AST_DECONF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        deconf |=> deconf); // R8
    AST_FILL_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !fill_ready); // R12
endmodule

bind secded_line_cache secded_cache_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .fill_ready (fill_ready),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_ce     (rsp_ce),
    .rsp_ue     (rsp_ue),
    .deconf     (deconf)
);

// File: tb/sim_secded_line_cache.sv
`timescale 1ns/1ps
module sim_secded_line_cache;
    localparam int SETS    = 4;
    localparam int WAYS    = 2;
    localparam int TAG_W   = 8;
    localparam int THRESH  = 2;
    localparam int MAX_DEL = 6;
    localparam int IDX_W   = 2;
    localparam int ADDR_W  = TAG_W + IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_ce, rsp_ue;
    logic [63:0]       rsp_data;
    logic              fill_valid = 1'b0;
    logic              fill_ready;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [63:0]       fill_data = '0;
    logic [71:0]       fill_flip = '0;
    logic              deconf;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    secded_line_cache #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
                        .THRESH(THRESH), .MAX_DEL(MAX_DEL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ce(rsp_ce),
        .rsp_ue(rsp_ue), .rsp_data(rsp_data),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_flip(fill_flip), .deconf(deconf)
    );

    // reference model built from the requirements
    logic        m_vld  [SETS][WAYS];
    logic        m_del  [SETS][WAYS];
    logic [7:0]  m_tag  [SETS][WAYS];
    logic [63:0] m_data [SETS][WAYS];
    logic [71:0] m_flip [SETS][WAYS];
    int          m_cnt  [SETS][WAYS];
    int          m_rr   [SETS];
    int          m_dcnt;
    logic        m_deconf;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_vld[s][w] = 0; m_del[s][w] = 0; m_tag[s][w] = '0;
                m_data[s][w] = '0; m_flip[s][w] = '0; m_cnt[s][w] = 0;
            end
        end
        m_dcnt = 0;
        m_deconf = 0;
    endtask

    function automatic int find_hit(input int s, input logic [7:0] t);
        for (int w = 0; w < WAYS; w++)
            if (m_vld[s][w] && !m_del[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        fill_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_fill(input int s, input logic [7:0] t, input logic [63:0] dd, input logic [71:0] f);
        int w;
        @(negedge clk);
        while (!fill_ready) @(negedge clk);
        fill_valid = 1'b1;
        fill_addr = {t, IDX_W'(s)};
        fill_data = dd;
        fill_flip = f;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        // R11 placement order, R6 count restart, R7 retired ways skipped
        w = find_hit(s, t);
        if (w < 0) begin
            for (int k = WAYS - 1; k >= 0; k--)
                if (!m_del[s][k] && !m_vld[s][k]) w = k;
            if (w >= 0) m_cnt[s][w] = 0;
        end
        if (w < 0) begin
            for (int k = WAYS - 1; k >= 0; k--)
                if (!m_del[s][(m_rr[s] + k) % WAYS]) w = (m_rr[s] + k) % WAYS;
            if (w >= 0) begin
                m_cnt[s][w] = 0;
                m_rr[s] = (w + 1) % WAYS;
            end
        end
        if (w >= 0) begin
            m_vld[s][w] = 1; m_tag[s][w] = t; m_data[s][w] = dd; m_flip[s][w] = f;
        end
    endtask

    task automatic do_read(input int s, input logic [7:0] t, input string rq);
        int  w;
        int  nf;
        bit  e_hit, e_ce, e_ue;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr = {t, IDX_W'(s)};
        #1;
        chk(fill_ready == 1'b0, "R12 fill held off by request", 64'(fill_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        w = find_hit(s, t);
        e_hit = (w >= 0);
        nf = e_hit ? $countones(m_flip[s][w]) : 0;
        e_ce = e_hit && nf == 1;
        e_ue = e_hit && nf == 2;
        chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_hit == e_hit, {rq, " hit"}, 64'(rsp_hit), 64'(e_hit));
        chk(rsp_ce == e_ce, {rq, " ce"}, 64'(rsp_ce), 64'(e_ce));
        chk(rsp_ue == e_ue, {rq, " ue"}, 64'(rsp_ue), 64'(e_ue));
        if (e_hit && !e_ue)
            chk(rsp_data == m_data[s][w], {rq, " data"}, rsp_data, m_data[s][w]);
        if (e_ce) begin
            chk(req_ready == 1'b0, "R4 stall during write-back", 64'(req_ready), 64'd0);
            chk(fill_ready == 1'b0, "R12 no fill during write-back", 64'(fill_ready), 64'd0);
            m_flip[s][w] = '0;
            if (m_cnt[s][w] < THRESH) m_cnt[s][w]++;
            if (m_cnt[s][w] == THRESH && m_dcnt < MAX_DEL) begin
                m_del[s][w] = 1; m_vld[s][w] = 0; m_dcnt++;
                if (m_dcnt == MAX_DEL) m_deconf = 1;
            end
            @(negedge clk);
            chk(req_ready == 1'b1, "R4 ready after one cycle", 64'(req_ready), 64'd1);
            chk(rsp_valid == 1'b0, "R9 single-cycle response", 64'(rsp_valid), 64'd0);
        end
        chk(deconf == m_deconf, "R8 deconf flag", 64'(deconf), 64'(m_deconf));
    endtask

    function automatic logic [71:0] one_bit(input int p);
        logic [71:0] m;
        m = '0;
        m[p] = 1'b1;
        return m;
    endfunction

    task automatic retire(input int s, input logic [7:0] t, input string rq);
        do_fill(s, t, {32'hC0DE0000 + 32'(t), 32'h5A5A0000 + 32'(s)}, one_bit(5));
        do_read(s, t, {rq, " first ce"});
        do_fill(s, t, {32'hC0DE0000 + 32'(t), 32'h5A5A0000 + 32'(s)}, one_bit(44));
        do_read(s, t, {rq, " second ce"});
        do_read(s, t, {rq, " after threshold"});
    endtask

    initial begin
        wait (cyc >= 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int a, b, r;
        logic [71:0] f;
        void'($urandom(32'h5EC0DED));
        do_reset();

        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 no response after reset", 64'(rsp_valid), 64'd0);
        chk(deconf == 1'b0, "R10 deconf clear", 64'(deconf), 64'd0);
        chk(fill_ready == 1'b1, "R12 fill ready when idle", 64'(fill_ready), 64'd1);
        do_read(0, 8'd5, "R10 empty cache misses");

        do_fill(0, 8'd5, 64'h0123_4567_89AB_CDEF, '0);
        do_read(0, 8'd5, "R9 clean hit");
        do_read(0, 8'd6, "R9 tag mismatch miss");

        do_fill(1, 8'd3, 64'hFEED_FACE_DEAD_BEEF, one_bit(17));
        do_read(1, 8'd3, "R1 single-bit corrected");
        do_read(1, 8'd3, "R2 repaired line reads clean");

        // R6: new tag evicts the counted way and restarts its count
        do_fill(1, 8'd4, 64'h1111_2222_3333_4444, '0);
        do_fill(1, 8'd6, 64'h5555_6666_7777_8888, one_bit(2));
        do_read(1, 8'd6, "R6 ce on fresh line");
        do_read(1, 8'd6, "R6 fresh line not retired");

        do_fill(2, 8'd9, 64'hAAAA_BBBB_CCCC_DDDD, one_bit(3) | one_bit(40));
        do_read(2, 8'd9, "R3 double error flagged");
        do_read(2, 8'd9, "R3 double error not repaired");

        // R5 threshold, update fill keeps count
        do_fill(3, 8'd1, 64'h0F0F_0F0F_F0F0_F0F0, one_bit(0));
        do_read(3, 8'd1, "R5 first ce");
        do_fill(3, 8'd1, 64'h0F0F_0F0F_F0F0_F0F0, one_bit(71));
        do_read(3, 8'd1, "R5 threshold ce corrected");
        do_read(3, 8'd1, "R5 retired line misses");
        do_fill(3, 8'd2, 64'h2, '0);
        do_fill(3, 8'd4, 64'h4, '0);
        do_read(3, 8'd2, "R7 only usable way evicted");
        do_read(3, 8'd4, "R7 fill avoids retired way");

        // R11 placement order
        do_fill(0, 8'd7, 64'h7, '0);
        do_fill(0, 8'd8, 64'h8, '0);
        do_read(0, 8'd5, "R11 round robin evicts way 0");
        do_read(0, 8'd7, "R11 way 1 kept");
        do_read(0, 8'd8, "R11 new line present");
        do_fill(0, 8'd10, 64'hA, '0);
        do_read(0, 8'd7, "R11 pointer moved to way 1");
        do_read(0, 8'd10, "R11 new line present");

        // R8 fill the retirement table
        retire(0, 8'd20, "R8 retire");
        retire(0, 8'd21, "R8 retire");
        retire(1, 8'd22, "R8 retire");
        retire(1, 8'd23, "R8 retire");
        retire(2, 8'd24, "R8 sixth retire");
        chk(deconf == 1'b1, "R8 deconf after sixth", 64'(deconf), 64'd1);
        retire(3, 8'd25, "R8 table full keeps line");
        do_fill(0, 8'd30, 64'h30, '0);
        do_read(0, 8'd30, "R7 fully retired set drops fill");

        // constrained random phase from a clean state
        do_reset();
        @(negedge clk);
        chk(deconf == 1'b0, "R10 deconf cleared by reset", 64'(deconf), 64'd0);
        for (int i = 0; i < 400; i++) begin
            a = int'($urandom % SETS);
            b = int'($urandom % 4);
            if ($urandom % 3 == 0) begin
                r = int'($urandom % 10);
                f = '0;
                if (r >= 6) f = one_bit(int'($urandom % 72));
                if (r >= 8) begin
                    int p2;
                    p2 = int'($urandom % 72);
                    while (f[p2]) p2 = int'($urandom % 72);
                    f = f | one_bit(p2);
                end
                do_fill(a, 8'(b), {$urandom, $urandom}, f);
            end else begin
                do_read(a, 8'(b), "R1/R3/R5/R9 random lookup");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule